// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the master side of a four-wire serial link to a 12-bit multichannel analog-to-digital converter. A one-cycle start request carries a 3-bit channel number, a single-ended/differential selector and a mirror-check enable. The controller lowers chip select and runs a serial clock divided down from the system clock. It sends the five-bit command and lets the sample interval pass. It then reads a null bit and the twelve result bits, and returns the word with a one-cycle valid strobe, tagged with the channel and mode it was read from.

When mirror checking is enabled, the controller clocks eleven more bits after the result. The converter repeats the word least significant bit first over those clocks, and the controller compares that copy with the word read first. A null bit read as one, or a copy that differs, raises the error output in the same cycle as the valid strobe. After every read, chip select stays high for a parameterised number of system clocks before the next request is taken.

Top module: `adc_capture_ctrl`

## Requirements
- R1: While `busy_o` is low, a cycle with `start_i` high is accepted: in the next cycle `cs_n_o` is low and `busy_o` is high. A `start_i` seen while `busy_o` is high has no effect on the transfer in progress or on its tags.
- R2: `sclk_o` is low whenever chip select is high. It first rises HALF_DIV system clocks after chip select falls, and every high or low phase lasts exactly HALF_DIV system clocks.
- R3: `mosi_o` carries the command MSB first: a 1 (start), then `single_i`, then `chan_i[2]`, `chan_i[1]` and `chan_i[0]`, followed by 0. The start bit is present from the fall of chip select. After that, `mosi_o` changes only in the cycle in which `sclk_o` falls.
- R4: `miso_i` is sampled on serial-clock rising edges. Its value at rising edges 1 to 6 has no effect on any output.
- R5: Rising edge 7 samples the null bit. A value of 1 there makes `err_o` high alongside the valid strobe.
- R6: Rising edges 8 to 19 sample the result from bit 11 down to bit 0. `data_o` presents it as a normal binary word.
- R7: `valid_o` is high for exactly one cycle, the cycle in which `cs_n_o` returns high. This happens after falling edge 19, or after falling edge 30 in mirror mode. `data_o`, `chan_o`, `single_o` and `err_o` are valid in that cycle, with `chan_o` and `single_o` equal to the request's channel and mode.
- R8: With `mirror_i` set, rising edges 20 to 30 sample result bits 1 to 11 in that order. Any difference from the word read first raises `err_o`. Without `mirror_i`, only 19 clocks are run and `err_o` depends on the null bit alone.
- R9: After chip select rises, `busy_o` stays high for exactly CS_HIGH more system clocks. Chip select is never low while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one conversion read |
| chan_i | input | 3 | Channel number for the request |
| single_i | input | 1 | 1 = single-ended input, 0 = differential pair |
| mirror_i | input | 1 | Also read and compare the LSB-first copy |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial command data to the converter |
| busy_o | output | 1 | Transfer or chip-select recovery in progress |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | 12 | Conversion result |
| chan_o | output | 3 | Channel the result belongs to |
| single_o | output | 1 | Mode the result belongs to |
| err_o | output | 1 | Null bit nonzero or mirror mismatch |

## Verification
Some properties are checked by assertions on every cycle. The serial clock stays low while chip select is high, and `mosi_o` moves only when the serial clock falls. The valid strobe is a single cycle that coincides with the rise of chip select, and chip select never drops outside a busy window. Other behaviour needs the bench's scenarios and its behavioural converter model. That covers the command bits the converter actually receives and the bit positions of the result. It also covers the exact phase widths and the recovery time, the insensitivity to line noise before the null bit, error reporting for a bad null bit or a corrupted mirror copy, and the rejection of a request made mid-transfer.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    localparam int RES_W     = 12;
    localparam int CH_W      = 3;
    localparam int CMD_BITS  = 2 + CH_W;
    localparam int K_NULL    = CMD_BITS + 2;
    localparam int K_FIRST   = K_NULL + 1;
    localparam int K_LAST    = K_FIRST + RES_W - 1;
    localparam int K_MIR_END = K_LAST + RES_W - 1;
    localparam int K_W       = $clog2(K_MIR_END + 1);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_RECOV = 2'd2
    } ctrl_state_e;

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = $clog2(HALF_DIV + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == CNT_LAST);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST) else $error("divider count out of range"); // R2

endmodule

// File: rtl/adc_mirror_cmp.sv
module adc_mirror_cmp #(
    parameter int RES_W = 12
) (
    input  logic [RES_W-1:0] word_i,
    input  logic [RES_W-2:0] mirror_i,
    output logic             mismatch_o
);
    logic [RES_W-2:0] diff;

    for (genvar b = 0; b < RES_W - 1; b++) begin : g_bit
        assign diff[b] = word_i[b+1] ^ mirror_i[b];
    end

    assign mismatch_o = |diff;

endmodule

// File: rtl/adc_capture_ctrl.sv
module adc_capture_ctrl
    import adc_cap_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int CS_HIGH  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [CH_W-1:0]     chan_i,
    input  logic                single_i,
    input  logic                mirror_i,
    input  logic                miso_i,
    output logic                cs_n_o,
    output logic                sclk_o,
    output logic                mosi_o,
    output logic                busy_o,
    output logic                valid_o,
    output logic [RES_W-1:0]    data_o,
    output logic [CH_W-1:0]     chan_o,
    output logic                single_o,
    output logic                err_o
);
    localparam int HC_W = $clog2(CS_HIGH + 1);
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(CS_HIGH - 1);
    localparam logic [K_W-1:0]  KN_NULL  = K_W'(K_NULL);
    localparam logic [K_W-1:0]  KN_FIRST = K_W'(K_FIRST);
    localparam logic [K_W-1:0]  KN_LAST  = K_W'(K_LAST);
    localparam logic [K_W-1:0]  KN_MEND  = K_W'(K_MIR_END);

    typedef struct packed {
        ctrl_state_e          st;
        logic                 cs_n;
        logic                 sclk;
        logic                 mosi;
        logic [K_W-1:0]       k;
        logic [CMD_BITS-2:0]  cmd_sh;
        logic [CH_W-1:0]      tag_ch;
        logic                 tag_single;
        logic                 mir_en;
        logic [RES_W-1:0]     word;
        logic [RES_W-2:0]     mir;
        logic                 null_bad;
        logic [HC_W-1:0]      hcnt;
        logic                 valid;
        logic [RES_W-1:0]     data;
        logic [CH_W-1:0]      chan;
        logic                 single;
        logic                 err;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;
    logic       tick;
    logic       mismatch;
    logic [K_W-1:0] k_next;
    logic [K_W-1:0] k_end;

    adc_sclk_div #(.HALF_DIV(HALF_DIV)) div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (r_q.st == ST_SHIFT),
        .tick_o (tick)
    );

    adc_mirror_cmp #(.RES_W(RES_W)) cmp_i (
        .word_i     (r_q.word),
        .mirror_i   (r_q.mir),
        .mismatch_o (mismatch)
    );

    always_comb begin
        r_d     = r_q;
        r_d.valid = 1'b0;
        k_next  = r_q.k + 1'b1;
        k_end   = r_q.mir_en ? KN_MEND : KN_LAST;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st         = ST_SHIFT;
                    r_d.cs_n       = 1'b0;
                    r_d.sclk       = 1'b0;
                    r_d.mosi       = 1'b1;
                    r_d.cmd_sh     = {single_i, chan_i};
                    r_d.tag_ch     = chan_i;
                    r_d.tag_single = single_i;
                    r_d.mir_en     = mirror_i;
                    r_d.k          = '0;
                    r_d.word       = '0;
                    r_d.mir        = '0;
                    r_d.null_bad   = 1'b0;
                end
            end
            ST_SHIFT: begin
                if (tick && !r_q.sclk) begin
                    r_d.sclk = 1'b1;
                    r_d.k    = k_next;
                    if (k_next == KN_NULL) begin
                        r_d.null_bad = miso_i;
                    end else if (k_next >= KN_FIRST && k_next <= KN_LAST) begin
                        r_d.word = {r_q.word[RES_W-2:0], miso_i};
                    end else if (k_next > KN_LAST && k_next <= KN_MEND) begin
                        r_d.mir = {miso_i, r_q.mir[RES_W-2:1]};
                    end
                end else if (tick && r_q.sclk) begin
                    r_d.sclk   = 1'b0;
                    r_d.mosi   = r_q.cmd_sh[CMD_BITS-2];
                    r_d.cmd_sh = {r_q.cmd_sh[CMD_BITS-3:0], 1'b0};
                    if (r_q.k == k_end) begin
                        r_d.st     = ST_RECOV;
                        r_d.cs_n   = 1'b1;
                        r_d.mosi   = 1'b0;
                        r_d.hcnt   = '0;
                        r_d.valid  = 1'b1;
                        r_d.data   = r_q.word;
                        r_d.chan   = r_q.tag_ch;
                        r_d.single = r_q.tag_single;
                        r_d.err    = r_q.null_bad | (r_q.mir_en & mismatch);
                    end
                end
            end
            ST_RECOV: begin
                if (r_q.hcnt == HC_LAST) r_d.st = ST_IDLE;
                else                     r_d.hcnt = r_q.hcnt + 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.cs_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n_o   = r_q.cs_n;
    assign sclk_o   = r_q.sclk;
    assign mosi_o   = r_q.mosi;
    assign busy_o   = (r_q.st != ST_IDLE);
    assign valid_o  = r_q.valid;
    assign data_o   = r_q.data;
    assign chan_o   = r_q.chan;
    assign single_o = r_q.single;
    assign err_o    = r_q.err;

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o) else $error("sclk high with chip select high"); // R2

    AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi_o) |-> ($fell(sclk_o) || $fell(cs_n_o) || $rose(cs_n_o)))
        else $error("mosi moved outside a falling edge"); // R3

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o) else $error("valid longer than one cycle"); // R7

    AST_VALID_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $rose(cs_n_o)) else $error("valid without chip select rise"); // R7

    AST_CS_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o) else $error("chip select low while idle"); // R9

    AST_RECOV_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_RECOV) |-> (cs_n_o && !sclk_o)) else $error("recovery with link active"); // R9

    AST_CLOCK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.k <= KN_MEND) else $error("too many serial clocks"); // R8

endmodule

// File: tb/adc_capture_ctrl_tb.sv
module adc_capture_ctrl_tb_top;
    localparam int H   = 2;
    localparam int CSH = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [2:0] chan_i = '0;
    logic single_i = 1'b0;
    logic mirror_i = 1'b0;
    logic miso_i;
    logic cs_n_o, sclk_o, mosi_o, busy_o, valid_o, single_o, err_o;
    logic [11:0] data_o;
    logic [2:0] chan_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_capture_ctrl #(.HALF_DIV(H), .CS_HIGH(CSH)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .single_i(single_i), .mirror_i(mirror_i), .miso_i(miso_i),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .mosi_o(mosi_o), .busy_o(busy_o),
        .valid_o(valid_o), .data_o(data_o), .chan_o(chan_o),
        .single_o(single_o), .err_o(err_o)
    );

    // behavioural converter
    logic [4:0]  s_cmd = '0;
    logic [11:0] s_val = '0;
    int          s_k = 0;
    logic        hiz_val = 1'b1;
    logic        bad_null = 1'b0;
    logic        bad_mir = 1'b0;
    logic        s_miso = 1'b0;
    assign miso_i = s_miso;

    function automatic logic [11:0] conv(input logic [4:0] c);
        return 12'((int'(c) * 331 + 90) % 4096);
    endfunction

    always @(negedge cs_n_o) begin
        s_k = 0;
        s_cmd = '0;
        s_miso = hiz_val;
    end

    always @(posedge sclk_o) if (cs_n_o == 1'b0) begin
        s_k++;
        if (s_k <= 5) s_cmd = {s_cmd[3:0], mosi_o};
        if (s_k == 5) s_val = conv(s_cmd);
    end

    always @(negedge sclk_o) if (cs_n_o == 1'b0) begin
        int nk;
        nk = s_k + 1;
        if (nk < 7)                  s_miso = hiz_val;
        else if (nk == 7)            s_miso = bad_null;
        else if (nk <= 19)           s_miso = s_val[19 - nk];
        else if (nk <= 30)           s_miso = s_val[nk - 19] ^ (bad_mir && nk == 25);
        else                         s_miso = 1'b0;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // one read with the per-cycle reference timing
    task automatic txn(input logic [2:0] ch, input logic sgl, input logic mir,
                       input logic hz, input logic bn, input logic bm, input bit poke);
        int n_clk, t_end;
        logic [4:0] cmd;
        n_clk = mir ? 30 : 19;
        t_end = 2 * n_clk * H;
        cmd = {1'b1, sgl, ch};
        hiz_val = hz; bad_null = bn; bad_mir = bm;
        @(negedge clk);
        start_i = 1'b1; chan_i = ch; single_i = sgl; mirror_i = mir;
        @(negedge clk);
        start_i = 1'b0;
        for (int c = 0; c <= t_end + CSH; c++) begin
            chk("R1/R9 cs_n", int'(cs_n_o), int'(c >= t_end));
            chk("R2 sclk", int'(sclk_o), (c < t_end) ? ((c / H) % 2) : 0);
            chk("R9 busy", int'(busy_o), int'(c < t_end + CSH));
            chk("R7 valid", int'(valid_o), int'(c == t_end));
            if (c == 0) chk("R3 start bit", int'(mosi_o), 1);
            if (c == t_end) begin
                chk("R3 command received", int'(s_cmd), int'(cmd));
                chk("R6 data", int'(data_o), int'(conv(cmd)));
                chk("R7 chan tag", int'(chan_o), int'(ch));
                chk("R7 mode tag", int'(single_o), int'(sgl));
                chk("R5/R8 err", int'(err_o), int'(bn | (mir & bm)));
            end
            if (poke && c == 3) begin
                start_i = 1'b1; chan_i = ~ch; single_i = ~sgl; mirror_i = ~mir;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset cs_n", int'(cs_n_o), 1);
        chk("R2 reset sclk", int'(sclk_o), 0);
        chk("R9 reset busy", int'(busy_o), 0);
        chk("R7 reset valid", int'(valid_o), 0);
        chk("R3 reset mosi", int'(mosi_o), 0);
        // every channel, mode and mirror setting (R6, R8)
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 2; s++)
                for (int ch = 0; ch < 8; ch++)
                    txn(3'(ch), s[0], m[0], ch[0], 1'b0, 1'b0, 1'b0);
        // R4: line noise before the null bit changes nothing
        txn(3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        txn(3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        // R5: bad null bit
        txn(3'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        txn(3'd6, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        // R8: corrupted mirror copy, and ignored without mirror mode
        txn(3'd7, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        txn(3'd7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        // R1: request while busy is ignored
        txn(3'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        txn(3'd4, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule